// File: doc/BRIEF.md
# MII Station Management Controller

This block carries out management reads and writes to PHY registers over a two-wire serial management link. Software first loads a 16-bit station data register. It then writes a station command register that holds a PHY address, a register address and a direction bit. That command write starts the serial transaction by itself, and the command register reports a busy flag that is set from the very next cycle.

The controller divides the system clock down to a management clock. It shifts out a framed command and either sends the data register's value or turns the data line around and collects 16 bits from the PHY. When the frame ends it pulses a completion strobe for one cycle. On a read it then places the collected value into the data register. When no PHY answers, the pulled-up line reads back as all ones, so the stored value is 0xFFFF.

Top module: `mdio_station_ctrl`

## Requirements
- R1: A command write while idle sets the busy flag (bit 11 of the command readback) in the cycle that follows the write, and starts a frame.
- R2: Command bit 10 selects the direction. 1 is a write and sends opcode bits 01. 0 is a read and sends opcode bits 10.
- R3: The frame carries the PHY address from command bits [9:5] and then the register address from command bits [4:0], each 5 bits, most significant bit first.
- R4: For a write, the 16 data bits of the frame equal the station data register value held when the command was written.
- R5: For a read of a PHY that drives the line, the 16 bits sampled on the rising management-clock edges of the data phase are stored in the station data register when busy clears.
- R6: For a read where no PHY drives the line (input held high), the station data register becomes 0xFFFF.
- R7: Completion is a single-cycle pulse with busy still set. Busy clears on the next cycle.
- R8: Each frame has exactly 64 management-clock periods. The order is 32 ones, start bits 01, opcode, addresses, turnaround, then data. The turnaround is driven as 10 on a write. On a read the output enable is released from the turnaround onward.
- R9: The management clock period is 2*MDC_HALF system clocks. The clock rests low, with the output enable off, while idle.
- R10: A command write while busy is ignored. The command fields and the frame in flight do not change.
- R11: A data-register write while busy is ignored, including one in the completion cycle.
- R12: After reset, busy, command fields, data register, management clock, output enable and completion are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sta_data_we | input | 1 | Write strobe for the station data register |
| sta_data_wval | input | 16 | Value for the station data register |
| sta_cmd_we | input | 1 | Write strobe for the command register; starts a frame when idle |
| sta_cmd_wval | input | 11 | {direction, PHY address[4:0], register address[4:0]} |
| sta_cmd_rd | output | 12 | {busy, direction, PHY address, register address} |
| sta_data_rd | output | 16 | Station data register |
| xfer_done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Output enable for the serial data line |
| mdio_in | input | 1 | Serial data from the line (pulled high when undriven) |

## Verification
Two events can fall in the same cycle: a read finishing and a new write to the data or command register. The bench provokes this by driving both registers during the exact cycle in which the completion pulse is high. It then judges that the read value, not the written one, sits in the data register, and that the command fields are unchanged. The bench also writes both registers in the middle of a frame and compares every captured frame bit against a frame it builds itself.

// File: rtl/mdio_station_pkg.sv
package mdio_station_pkg;
  localparam int unsigned FLD_W   = 5;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned PRE_LEN = 32;
  localparam int unsigned CMD_W   = 2 * FLD_W + 1;
  localparam int unsigned FRAME_LEN = PRE_LEN + 4 + 2 * FLD_W + 2 + WORD_W;
  localparam int unsigned TA_IDX   = PRE_LEN + 4 + 2 * FLD_W;
  localparam int unsigned DATA_IDX = TA_IDX + 2;

  typedef struct packed {
    logic             wr;
    logic [FLD_W-1:0] phy;
    logic [FLD_W-1:0] reg_a;
  } sta_cmd_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(input sta_cmd_t c,
                                                       input logic [WORD_W-1:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.wr ? 2'b01 : 2'b10;
    ta = 2'b10;
    return {{PRE_LEN{1'b1}}, 2'b01, op, c.phy, c.reg_a, ta, d};
  endfunction
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int unsigned CNT_W = $clog2(HALF + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap    = run && (cnt_q == CNT_W'(HALF - 1));
  assign rise_ev = wrap && !mdc;
  assign fall_ev = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_station_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  sta_cmd_t          cmd,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rise_ev,
  input  logic              fall_ev,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic              run,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [WORD_W-1:0] rdata
);
  localparam int unsigned IDX_W = $clog2(FRAME_LEN);

  logic [FRAME_LEN-1:0] shift_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 wr_q;

  assign run    = busy && !done;
  assign mdio_o = shift_q[FRAME_LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx_q   <= '0;
      shift_q <= '0;
      mdio_oe <= 1'b0;
      wr_q    <= 1'b0;
      rdata   <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      shift_q <= build_frame(cmd, wdata);
      idx_q   <= '0;
      mdio_oe <= 1'b1;
      wr_q    <= cmd.wr;
      rdata   <= '0;
    end else if (done) begin
      done <= 1'b0;
      busy <= 1'b0;
    end else if (busy) begin
      if (rise_ev && !wr_q && idx_q >= IDX_W'(DATA_IDX))
        rdata <= {rdata[WORD_W-2:0], mdio_i};
      if (fall_ev) begin
        if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
          done    <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx_q   <= idx_q + 1'b1;
          shift_q <= {shift_q[FRAME_LEN-2:0], 1'b1};
          if (!wr_q && idx_q == IDX_W'(TA_IDX - 1))
            mdio_oe <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_station_ctrl.sv
module mdio_station_ctrl
  import mdio_station_pkg::*;
#(
  parameter int unsigned MDC_HALF = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sta_data_we,
  input  logic [WORD_W-1:0]   sta_data_wval,
  input  logic                sta_cmd_we,
  input  logic [CMD_W-1:0]    sta_cmd_wval,
  output logic [CMD_W:0]      sta_cmd_rd,
  output logic [WORD_W-1:0]   sta_data_rd,
  output logic                xfer_done,
  output logic                mdc,
  output logic                mdio_out,
  output logic                mdio_oe,
  input  logic                mdio_in
);
  sta_cmd_t          cmd_q;
  sta_cmd_t          cmd_new;
  logic [WORD_W-1:0] data_q;
  logic              busy;
  logic              done;
  logic              run;
  logic              rise_ev;
  logic              fall_ev;
  logic [WORD_W-1:0] rdata;

  assign cmd_new = sta_cmd_t'(sta_cmd_wval);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (sta_cmd_we && !busy)
        cmd_q <= cmd_new;
      if (done && !cmd_q.wr)
        data_q <= rdata;
      else if (sta_data_we && !busy)
        data_q <= sta_data_wval;
    end
  end

  mdc_divider #(.HALF(MDC_HALF)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk     (clk),
    .rst     (rst),
    .start   (sta_cmd_we),
    .cmd     (cmd_new),
    .wdata   (data_q),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .mdio_i  (mdio_in),
    .busy    (busy),
    .done    (done),
    .run     (run),
    .mdio_o  (mdio_out),
    .mdio_oe (mdio_oe),
    .rdata   (rdata)
  );

  assign sta_cmd_rd  = {busy, cmd_q};
  assign sta_data_rd = data_q;
  assign xfer_done   = done;
endmodule

// File: rtl/mdio_station_chk.sv
module mdio_station_chk (
  input logic        clk,
  input logic        rst,
  input logic        sta_data_we,
  input logic        sta_cmd_we,
  input logic [11:0] sta_cmd_rd,
  input logic [15:0] sta_data_rd,
  input logic        xfer_done,
  input logic        mdc,
  input logic        mdio_oe
);
  logic busy;
  assign busy = sta_cmd_rd[11];

  // R1
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && sta_cmd_we) |=> busy);

  // R1
  busy_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(sta_cmd_we));

  // R7
  done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> (!xfer_done && !busy));

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && sta_cmd_we) |=> $stable(sta_cmd_rd[10:0]));

  // R11
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(sta_data_rd));

  // R11
  data_we_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && sta_data_we && !xfer_done) |=> $stable(sta_data_rd));
endmodule

bind mdio_station_ctrl mdio_station_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sta_data_we (sta_data_we),
  .sta_cmd_we  (sta_cmd_we),
  .sta_cmd_rd  (sta_cmd_rd),
  .sta_data_rd (sta_data_rd),
  .xfer_done   (xfer_done),
  .mdc         (mdc),
  .mdio_oe     (mdio_oe)
);

// File: tb/test_mdio_station_ctrl.sv
`timescale 1ns/1ps
module test_mdio_station_ctrl;
  localparam int unsigned HALF = 2;
  localparam logic [4:0] PA = 5'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sta_data_we = 1'b0;
  logic [15:0] sta_data_wval = '0;
  logic        sta_cmd_we = 1'b0;
  logic [10:0] sta_cmd_wval = '0;
  logic [11:0] sta_cmd_rd;
  logic [15:0] sta_data_rd;
  logic        xfer_done;
  logic        mdc;
  logic        mdio_out;
  logic        mdio_oe;
  logic        mdio_in;

  int n_chk = 0;
  int n_fail = 0;

  logic        rd_present = 1'b0;
  logic [15:0] rd_val = '0;
  logic [6:0]  mcnt = '0;
  logic [63:0] cap = '0;
  logic        mdc_d = 1'b0;
  time         t_last = 0;
  time         t_prev = 0;
  logic [15:0] model [32];

  always #5 clk = ~clk;

  mdio_station_ctrl #(.MDC_HALF(HALF)) i_mdio_station_ctrl (
    .clk(clk), .rst(rst),
    .sta_data_we(sta_data_we), .sta_data_wval(sta_data_wval),
    .sta_cmd_we(sta_cmd_we), .sta_cmd_wval(sta_cmd_wval),
    .sta_cmd_rd(sta_cmd_rd), .sta_data_rd(sta_data_rd),
    .xfer_done(xfer_done), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY side: drives 0 in the second turnaround bit and the data bits MSB first
  assign mdio_in = (rd_present && mcnt == 7'd47) ? 1'b0 :
                   (rd_present && mcnt >= 7'd48 && mcnt <= 7'd63) ? rd_val[4'(7'd63 - mcnt)] :
                   1'b1;

  always @(posedge clk) begin
    mdc_d <= mdc;
    if (sta_cmd_we && !sta_cmd_rd[11]) begin
      mcnt <= '0;
    end else if (mdc && !mdc_d) begin
      mcnt   <= mcnt + 1'b1;
      cap    <= {cap[62:0], mdio_oe ? mdio_out : mdio_in};
      t_prev <= t_last;
      t_last <= $time;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [4:0] phy, input logic [4:0] ra,
                      input logic [15:0] wval, input bit poke_mid, input bit poke_done);
    logic [15:0] exp_d;
    logic [1:0]  exp_ta;
    logic [10:0] cmdv;
    cmdv = {wr, phy, ra};
    @(negedge clk);
    sta_data_we = 1'b1; sta_data_wval = wval;
    @(negedge clk);
    sta_data_we = 1'b0;
    rd_present = !wr && (phy == PA);
    rd_val = model[ra];
    sta_cmd_we = 1'b1; sta_cmd_wval = cmdv;
    @(negedge clk);
    sta_cmd_we = 1'b0;
    chk(sta_cmd_rd[11] == 1'b1, "R1 busy", {63'd0, sta_cmd_rd[11]}, 64'd1);
    if (poke_mid) begin
      repeat (20) @(negedge clk);
      sta_cmd_we = 1'b1; sta_cmd_wval = ~cmdv;
      @(negedge clk);
      sta_cmd_we = 1'b0;
      chk(sta_cmd_rd[10:0] == cmdv, "R10 cmd ignored", {53'd0, sta_cmd_rd[10:0]}, {53'd0, cmdv});
      sta_data_we = 1'b1; sta_data_wval = ~wval;
      @(negedge clk);
      sta_data_we = 1'b0;
      chk(sta_data_rd == wval, "R11 data ignored", {48'd0, sta_data_rd}, {48'd0, wval});
    end
    while (!xfer_done) @(negedge clk);
    chk(sta_cmd_rd[11] == 1'b1, "R7 busy in done", {63'd0, sta_cmd_rd[11]}, 64'd1);
    if (poke_done) begin
      sta_data_we = 1'b1; sta_data_wval = 16'h5A5A;
      sta_cmd_we = 1'b1; sta_cmd_wval = ~cmdv;
    end
    @(negedge clk);
    sta_data_we = 1'b0; sta_cmd_we = 1'b0;
    chk(!xfer_done && !sta_cmd_rd[11], "R7 done pulse and busy clear",
        {62'd0, xfer_done, sta_cmd_rd[11]}, 64'd0);
    if (poke_done)
      chk(sta_cmd_rd[10:0] == cmdv, "R10 cmd ignored in done cycle",
          {53'd0, sta_cmd_rd[10:0]}, {53'd0, cmdv});
    exp_d  = wr ? wval : (rd_present ? model[ra] : 16'hFFFF);
    exp_ta = (wr || rd_present) ? 2'b10 : 2'b11;
    chk(mcnt == 7'd64, "R8 period count", {57'd0, mcnt}, 64'd64);
    chk(cap[63:30] == {32'hFFFF_FFFF, 2'b01}, "R8 preamble/start",
        {30'd0, cap[63:30]}, {30'd0, 32'hFFFF_FFFF, 2'b01});
    chk(cap[29:28] == (wr ? 2'b01 : 2'b10), "R2 opcode", {62'd0, cap[29:28]},
        {62'd0, (wr ? 2'b01 : 2'b10)});
    chk(cap[27:18] == {phy, ra}, "R3 addresses", {54'd0, cap[27:18]}, {54'd0, phy, ra});
    chk(cap[17:16] == exp_ta, "R8 turnaround", {62'd0, cap[17:16]}, {62'd0, exp_ta});
    if (wr)
      chk(cap[15:0] == wval, "R4 write data bits", {48'd0, cap[15:0]}, {48'd0, wval});
    else if (rd_present)
      chk(sta_data_rd == exp_d, "R5 read data stored", {48'd0, sta_data_rd}, {48'd0, exp_d});
    else
      chk(sta_data_rd == 16'hFFFF, "R6 absent PHY", {48'd0, sta_data_rd}, 64'hFFFF);
    if (poke_done || wr)
      chk(sta_data_rd == exp_d, "R11 data reg after done", {48'd0, sta_data_rd}, {48'd0, exp_d});
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R9 idle line", {62'd0, mdc, mdio_oe}, 64'd0);
    if (wr && phy == PA) model[ra] = wval;
    rd_present = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sta_cmd_rd == 12'd0 && sta_data_rd == 16'd0 && !mdc && !mdio_oe && !xfer_done,
        "R12 reset state", {35'd0, sta_cmd_rd, sta_data_rd, mdc, mdio_oe}, 64'd0);
    for (int r = 0; r < 32; r++)
      xfer(1'b1, PA, 5'(r), 16'((r * 16'h0919) ^ 16'hA5C3), r == 3, r == 7);
    chk(t_last - t_prev == time'(2 * HALF * 10), "R9 mdc period",
        64'(t_last - t_prev), 64'(2 * HALF * 10));
    for (int r = 0; r < 32; r++)
      xfer(1'b0, PA, 5'(r), 16'h1234, r == 9, (r % 4) == 1);
    xfer(1'b1, 5'd31, 5'd2, 16'hDEAD, 1'b0, 1'b0);
    for (int p = 0; p < 32; p += 6)
      xfer(1'b0, 5'(p), 5'(31 - p), 16'h0F0F, 1'b0, p == 12);
    xfer(1'b0, PA, 5'd2, 16'h0000, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule